// File: doc/BRIEF.md
# Dual Auto-Stepping Memory Window Ports

This block sits between a host's 8-bit register bus and a single-ported byte memory, and it gives the host two independent windows into that memory. Each window holds a 16-bit pointer, loaded one byte at a time, and a signed 8-bit step. Each access to the window's data register, read or write, goes to the memory location under the pointer. After the access the pointer moves by the sign-extended step and wraps modulo 65536. A host can therefore stream bytes forward, backward or with a stride, and never reload the pointer.

A control register holds two fields. One bit enables data reads for both windows. A two-bit mode field can mirror window 0 traffic into window 1. In the mirror mode, a write to window 0 lands at both pointers. A read from window 0 returns the byte to the host and also copies it to the location under pointer 1. Because the memory has a single port, the second memory cycle comes one clock after the strobe. A busy output is high during that cycle, and strobes that arrive while it is high are dropped. The bank select input passes straight through to the memory so that an outside bank selector can choose the active bank.

Top module: `stepwin_regs`

## Requirements
- R1: The register offsets are: 0 pointer-0 low byte, 1 pointer-0 high byte, 2 step 0, 3 data 0, 4 pointer-1 low byte, 5 pointer-1 high byte, 6 step 1, 7 data 1, and 8 control. In the control register, bit 0 is read enable and bits 5:4 are the mode; all other bits read 0. A read strobe on a non-data register puts its value on reg_rdata in the next cycle, and offsets 9 to 15 read 0x00.
- R2: After reset, both pointers, both steps, read enable and mode are 0, and busy is low.
- R3: A write strobe on a data offset drives mem_we in the same cycle, with mem_addr equal to that window's pointer and mem_wdata equal to reg_wdata. mem_bank always equals bank_sel, and mem_we and mem_re are never high together.
- R4: After each data access, the window's pointer becomes pointer plus the sign-extended step, modulo 65536. So 0xFFFF with step 1 gives 0x0000, and 0x0002 with step 0xFD gives 0xFFFF.
- R5: When read enable is 1, a read strobe on a data offset drives mem_re at the pointer in the same cycle. The memory byte appears on reg_rdata in the next cycle and stays there until the next read strobe.
- R6: When read enable is 0, a data read returns 0xFF, drives no memory cycle and leaves the pointer unchanged.
- R7: With mode 01, a write to data 0 stores the byte at pointer 0 in the strobe cycle and at pointer 1 in the next cycle. Busy is high in that next cycle, and both pointers advance by their own steps.
- R8: With mode 01 and read enable 1, a read of data 0 fetches the byte at pointer 0 and returns it to the host. In the next cycle, with busy high, the block writes that byte at pointer 1. Both pointers advance.
- R9: Modes 10 and 11 behave like mode 00: a write to data 0 touches only pointer 0's location, and busy stays low.
- R10: Read and write strobes in a cycle where busy is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid the cycle after the read strobe |
| busy | output | 1 | High during the second memory cycle of a mirrored access |
| bank_sel | input | BANK_W | Active memory bank |
| mem_addr | output | 16 | Memory byte address |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable (data returned next cycle) |
| mem_wdata | output | 8 | Memory write data |
| mem_bank | output | BANK_W | Bank select to memory |
| mem_rdata | input | 8 | Memory read data |

## Verification
Several properties are checked on every cycle. Busy never lasts more than one cycle, and strobes during it change no state. The memory never sees a read and a write at once. A window-0 write advances pointer 0 by its sign-extended step. A disabled read leaves pointer 0 alone and returns 0xFF. A mirrored read writes the fetched byte on the following cycle. Some behaviours need the bench's scenarios: register readback, pointer wrap in both directions, the exact addresses of the two mirrored memory cycles, reserved-mode values acting like normal mode, and the read data staying on reg_rdata after the read.

// File: rtl/stepwin_regs.sv
module stepwin_regs #(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              busy,
  input  logic [BANK_W-1:0] bank_sel,
  output logic [15:0]       mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [7:0]        mem_wdata,
  output logic [BANK_W-1:0] mem_bank,
  input  logic [7:0]        mem_rdata
);

  function automatic logic [15:0] sx(input logic [7:0] s);
    return {{8{s[7]}}, s};
  endfunction

  logic [15:0] ptr0, ptr1;
  logic [7:0]  step0, step1, hold, rd_q, reg_val;
  logic        rd_en, busy_q, cp_rd_q, rd_mem_q;
  logic [1:0]  mode;

  wire wr_ok  = reg_wr & ~busy_q;
  wire rd_ok  = reg_rd & ~reg_wr & ~busy_q;
  wire sel_d0 = reg_addr == 4'd3;
  wire sel_d1 = reg_addr == 4'd7;
  wire copy   = mode == 2'b01;
  wire acc0_wr = wr_ok & sel_d0;
  wire acc1_wr = wr_ok & sel_d1;
  wire acc0_rd = rd_ok & sel_d0 & rd_en;
  wire acc1_rd = rd_ok & sel_d1 & rd_en;

  assign busy      = busy_q;
  assign mem_bank  = bank_sel;
  assign mem_we    = acc0_wr | acc1_wr | busy_q;
  assign mem_re    = acc0_rd | acc1_rd;
  assign mem_addr  = (busy_q | sel_d1) ? ptr1 : ptr0;
  assign mem_wdata = busy_q ? (cp_rd_q ? mem_rdata : hold) : reg_wdata;
  assign reg_rdata = rd_mem_q ? mem_rdata : rd_q;

  always_comb begin
    case (reg_addr)
      4'd0:    reg_val = ptr0[7:0];
      4'd1:    reg_val = ptr0[15:8];
      4'd2:    reg_val = step0;
      4'd4:    reg_val = ptr1[7:0];
      4'd5:    reg_val = ptr1[15:8];
      4'd6:    reg_val = step1;
      4'd3, 4'd7: reg_val = 8'hFF;
      4'd8:    reg_val = {2'b00, mode, 3'b000, rd_en};
      default: reg_val = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr0 <= '0; ptr1 <= '0; step0 <= '0; step1 <= '0;
      rd_en <= 1'b0; mode <= 2'b00;
      busy_q <= 1'b0; cp_rd_q <= 1'b0; hold <= '0;
      rd_q <= '0; rd_mem_q <= 1'b0;
    end else begin
      if (wr_ok) begin
        case (reg_addr)
          4'd0: ptr0[7:0]  <= reg_wdata;
          4'd1: ptr0[15:8] <= reg_wdata;
          4'd2: step0      <= reg_wdata;
          4'd3: ptr0       <= ptr0 + sx(step0);
          4'd4: ptr1[7:0]  <= reg_wdata;
          4'd5: ptr1[15:8] <= reg_wdata;
          4'd6: step1      <= reg_wdata;
          4'd7: ptr1       <= ptr1 + sx(step1);
          4'd8: begin rd_en <= reg_wdata[0]; mode <= reg_wdata[5:4]; end
          default: ;
        endcase
      end
      if (acc0_rd) ptr0 <= ptr0 + sx(step0);
      if (acc1_rd || busy_q) ptr1 <= ptr1 + sx(step1);
      busy_q  <= (acc0_wr | acc0_rd) & copy;
      cp_rd_q <= acc0_rd;
      hold    <= reg_wdata;
      rd_mem_q <= acc0_rd | acc1_rd;
      if (rd_mem_q) rd_q <= mem_rdata;
      if (rd_ok)    rd_q <= reg_val;
    end
  end

  a_r7_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  a_r10_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ptr0) && $stable(step0) && $stable(step1) && $stable(mode) && $stable(rd_en));

  a_r3_no_rw_clash: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  a_r4_p0_step: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !busy && reg_addr == 4'd3) |=> ptr0 == $past(ptr0 + sx(step0)));

  a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && !busy && !rd_en && reg_addr == 4'd3)
      |=> $stable(ptr0) && reg_rdata == 8'hFF);

  a_r8_copy_read: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && !busy && rd_en && mode == 2'b01 && reg_addr == 4'd3)
      |=> busy && mem_we && mem_wdata == mem_rdata);

endmodule

// File: tb/test_stepwin_regs.sv
`timescale 1ns/1ps
module test_stepwin_regs;
  logic clk = 0, rst_n = 0;
  logic [3:0] reg_addr = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = 0, reg_rdata, mem_wdata, mem_rdata;
  logic busy, mem_we, mem_re;
  logic [1:0] bank_sel = 2'd2, mem_bank;
  logic [15:0] mem_addr;
  logic [7:0] mem [256];
  int checks = 0, errors = 0;
  logic s_we, s_re; logic [15:0] s_addr; logic [7:0] s_wd; logic [1:0] s_bank;
  logic [7:0] rv; logic [15:0] pv;

  always #2.5 clk = ~clk;

  stepwin_regs #(.BANK_W(2)) i_stepwin_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .bank_sel(bank_sel),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .mem_bank(mem_bank), .mem_rdata(mem_rdata));

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
  end

  // {is_read, offset, data-or-expected}
  localparam logic [12:0] VEC [16] = '{
    {1'b1,4'd0,8'h00}, {1'b1,4'd2,8'h00}, {1'b1,4'd6,8'h00}, {1'b1,4'd8,8'h00},
    {1'b0,4'd0,8'h34}, {1'b0,4'd1,8'h12}, {1'b0,4'd2,8'hFE}, {1'b0,4'd8,8'hFF},
    {1'b1,4'd0,8'h34}, {1'b1,4'd1,8'h12}, {1'b1,4'd2,8'hFE}, {1'b1,4'd8,8'h31},
    {1'b0,4'd4,8'hAB}, {1'b1,4'd4,8'hAB}, {1'b1,4'd9,8'h00}, {1'b0,4'd8,8'h00}};

  task automatic chk(input bit ok, input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic snap();
    s_we = mem_we; s_re = mem_re; s_addr = mem_addr; s_wd = mem_wdata; s_bank = mem_bank;
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1; #1 snap();
    @(negedge clk); reg_wr = 0; #1;
  endtask

  task automatic do_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 snap();
    @(negedge clk); reg_rd = 0; #1 d = reg_rdata;
  endtask

  task automatic get_ptr(input bit which, output logic [15:0] p);
    logic [7:0] lo, hi;
    do_rd(which ? 4'd4 : 4'd0, lo);
    do_rd(which ? 4'd5 : 4'd1, hi);
    p = {hi, lo};
  endtask

  task automatic set_ptr(input bit which, input logic [15:0] p, input logic [7:0] st);
    do_wr(which ? 4'd4 : 4'd0, p[7:0]);
    do_wr(which ? 4'd5 : 4'd1, p[15:8]);
    do_wr(which ? 4'd6 : 4'd2, st);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 chk(busy == 0, "R2 busy after reset", 16'(busy), 0);

    for (int i = 0; i < 16; i++) begin
      if (VEC[i][12]) begin
        do_rd(VEC[i][11:8], rv);
        chk(rv == VEC[i][7:0], i < 4 ? "R2 reset readback" : "R1 register readback", 16'(rv), 16'(VEC[i][7:0]));
      end else do_wr(VEC[i][11:8], VEC[i][7:0]);
    end

    // R3 write at pointer, R4 positive step
    set_ptr(0, 16'h0010, 8'd3);
    do_wr(4'd3, 8'h5A);
    chk(s_we && !s_re && s_addr == 16'h0010 && s_wd == 8'h5A, "R3 write strobe", s_addr, 16'h0010);
    chk(s_bank == 2'd2, "R3 bank passthrough", 16'(s_bank), 2);
    get_ptr(0, pv); chk(pv == 16'h0013, "R4 step forward", pv, 16'h0013);

    // R4 wrap up and down
    set_ptr(0, 16'hFFFF, 8'd1); do_wr(4'd3, 8'h11);
    get_ptr(0, pv); chk(pv == 16'h0000, "R4 wrap overflow", pv, 16'h0000);
    set_ptr(1, 16'h0002, 8'hFD); do_wr(4'd7, 8'h22);
    chk(s_addr == 16'h0002 && s_wd == 8'h22, "R3 port1 write", s_addr, 16'h0002);
    get_ptr(1, pv); chk(pv == 16'hFFFF, "R4 wrap underflow", pv, 16'hFFFF);

    // R6 disabled read
    set_ptr(0, 16'h0010, 8'd3);
    do_rd(4'd3, rv);
    chk(rv == 8'hFF, "R6 disabled data", 16'(rv), 16'hFF);
    chk(!s_re, "R6 no memory read", 16'(s_re), 0);
    get_ptr(0, pv); chk(pv == 16'h0010, "R6 pointer held", pv, 16'h0010);

    // R5 enabled read and hold
    do_wr(4'd8, 8'h01);
    do_rd(4'd3, rv);
    chk(s_re && s_addr == 16'h0010, "R5 read strobe", s_addr, 16'h0010);
    chk(rv == 8'h5A, "R5 read data", 16'(rv), 16'h5A);
    repeat (3) @(negedge clk);
    chk(reg_rdata == 8'h5A, "R5 read data held", 16'(reg_rdata), 16'h5A);
    get_ptr(0, pv); chk(pv == 16'h0013, "R5 pointer advanced", pv, 16'h0013);

    // R7 mirrored write, R10 strobe during busy
    do_wr(4'd8, 8'h11);
    set_ptr(0, 16'h0020, 8'd1); set_ptr(1, 16'h0040, 8'd2);
    @(negedge clk); reg_addr = 4'd3; reg_wdata = 8'hC3; reg_wr = 1; #1 snap();
    chk(s_addr == 16'h0020 && s_wd == 8'hC3, "R7 first cycle", s_addr, 16'h0020);
    @(negedge clk); reg_addr = 4'd0; reg_wdata = 8'h77; #1;
    chk(busy && mem_we && mem_addr == 16'h0040 && mem_wdata == 8'hC3, "R7 second cycle", mem_addr, 16'h0040);
    @(negedge clk); reg_wr = 0; #1;
    chk(busy == 0, "R7 busy one cycle", 16'(busy), 0);
    chk(mem[8'h40] == 8'hC3 && mem[8'h20] == 8'hC3, "R7 both stored", 16'(mem[8'h40]), 16'hC3);
    get_ptr(0, pv); chk(pv == 16'h0021, "R10 ignored during busy", pv, 16'h0021);
    get_ptr(1, pv); chk(pv == 16'h0042, "R7 pointer1 advanced", pv, 16'h0042);

    // R8 mirrored read
    set_ptr(0, 16'h0020, 8'd1); set_ptr(1, 16'h0050, 8'd2);
    do_rd(4'd3, rv);
    chk(rv == 8'hC3, "R8 data returned", 16'(rv), 16'hC3);
    chk(busy && mem_we && mem_addr == 16'h0050, "R8 copy cycle", mem_addr, 16'h0050);
    @(negedge clk);
    chk(mem[8'h50] == 8'hC3, "R8 byte copied", 16'(mem[8'h50]), 16'hC3);
    get_ptr(0, pv); chk(pv == 16'h0021, "R8 pointer0", pv, 16'h0021);
    get_ptr(1, pv); chk(pv == 16'h0052, "R8 pointer1", pv, 16'h0052);

    // R9 reserved modes
    do_wr(4'd8, 8'h21);
    set_ptr(0, 16'h0030, 8'd1); set_ptr(1, 16'h0060, 8'd1);
    do_wr(4'd3, 8'h99);
    chk(busy == 0, "R9 mode10 no busy", 16'(busy), 0);
    do_wr(4'd8, 8'h31);
    do_wr(4'd3, 8'h98);
    chk(busy == 0, "R9 mode11 no busy", 16'(busy), 0);
    @(negedge clk);
    chk(mem[8'h60] == 8'h00 && mem[8'h30] == 8'h99 && mem[8'h31] == 8'h98, "R9 no mirror", 16'(mem[8'h60]), 0);
    get_ptr(1, pv); chk(pv == 16'h0060, "R9 pointer1 held", pv, 16'h0060);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule